// File: doc/BRIEF.md
# Serial-Input Converter Word Receiver

This block is the digital front end of a serial-input digital-to-analog converter. An external source sends a bit clock, a serial data line and a latch strobe. The block samples all three into a fast system clock through a two-flop synchronizer. It shifts one data bit in on every rising edge of the bit clock, with the most significant bit first. When the latch strobe falls, the most recent 18 bits are moved into a parallel holding register that feeds the converter core.

The word is in two's complement. The block also presents the same value as an offset-binary code and gives a one-cycle update strobe for each word it accepts. The latch point is set by the strobe edge and not by a bit count, so a slot longer than 18 bits works: its leading pad bits drop out. The block also watches the width of the strobe in bit-clock periods. It raises a sticky error flag when the strobe breaks a width rule, and in that case it does not accept the word.

The system clock must run at least four times faster than the bit clock.

Top module: `serial_dac_rx`

## Requirements
- R1: Data is shifted in on each rising edge of the bit clock, most significant bit first.
- R2: The accepted word is the last 18 bits shifted in before the latch strobe falls. Any earlier pad bits in a longer slot have no effect on the word.
- R3: After reset, `word_o` reads 00000 hex, which is bipolar zero. `word_o` changes only when a word is accepted, and bit-clock edges on their own do not change it.
- R4: `word_ob_o` equals `word_o` with bit 17 inverted. Examples: 1FFFF (positive full scale) gives 3FFFF, 20000 (negative full scale) gives 00000, 00000 gives 20000, and 3FFFF (one step below zero) gives 1FFFF.
- R5: Each accepted word raises `upd_o` for exactly one system cycle. No pulse appears after reset until the first accepted word.
- R6: The latch strobe may fall only after at least one rising edge of the bit clock has occurred while it was high. If it falls earlier, `err_o` is set, `word_o` keeps its previous value and no `upd_o` pulse appears.
- R7: After the latch strobe falls, it must stay low until at least one rising edge of the bit clock has occurred. If it rises earlier, `err_o` is set, and the word already accepted stays on `word_o`.
- R8: Once set, `err_o` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Serial bit clock (asynchronous) |
| sdata_i | input | 1 | Serial data, MSB first (asynchronous) |
| lat_i | input | 1 | Latch strobe; its falling edge accepts the word (asynchronous) |
| word_o | output | 18 | Accepted word, two's complement |
| word_ob_o | output | 18 | Accepted word, offset binary |
| upd_o | output | 1 | One-cycle pulse when a word is accepted |
| err_o | output | 1 | Sticky latch-strobe width violation flag |

## Verification
A wrong shift order or a shift register of the wrong length shows at `word_o` right after the next strobe fall. The padded patterns make an off-by-one in the length visible, because the pad bits are ones. A wrong state in the width monitor shows as either an accepted word where `err_o` should have risen, or a flag raised on a legal frame. Either one appears within a few system cycles of the strobe edge. A strobe that repeats or goes missing is found by counting `upd_o` pulses for each frame.

// File: rtl/dac_rx_pkg.sv
package dac_rx_pkg;
    localparam int WORD_W = 18;
    typedef logic [WORD_W-1:0] word_t;

    // synchronized pin bundle
    typedef struct packed {
        logic lat;
        logic sdata;
        logic bclk;
    } pins_t;

    localparam int PINS_W = $bits(pins_t);

    // phase of the latch strobe as seen by the width monitor
    typedef enum logic [1:0] {
        PH_LOW_OK   = 2'd0,
        PH_LOW_WAIT = 2'd1,
        PH_HIGH_WAIT= 2'd2,
        PH_HIGH_OK  = 2'd3
    } lat_phase_e;

    function automatic word_t to_offset_bin(word_t w);
        word_t r;
        r = w;
        r[WORD_W-1] = ~w[WORD_W-1];
        return r;
    endfunction
endpackage

// File: rtl/dac_rx_sync.sv
module dac_rx_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] stage [STAGES];
    logic [N-1:0] prev;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage[g] <= '0;
                else if (g == 0) stage[g] <= din;
                else stage[g] <= stage[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= stage[STAGES-1];
    end

    assign lvl  = stage[STAGES-1];
    assign rise = stage[STAGES-1] & ~prev;
    assign fall = ~stage[STAGES-1] & prev;
endmodule

// File: rtl/dac_rx_shift.sv
module dac_rx_shift
    import dac_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  shift_en,
    input  logic  din,
    output word_t sh
);
    always_ff @(posedge clk) begin
        if (rst)           sh <= '0;
        else if (shift_en) sh <= {sh[WORD_W-2:0], din};
    end
endmodule

// File: rtl/dac_rx_guard.sv
module dac_rx_guard
    import dac_rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bclk_rise,
    input  logic lat_rise,
    input  logic lat_fall,
    output logic commit,
    output logic viol
);
    lat_phase_e ph, ph_n;

    always_comb begin
        ph_n   = ph;
        commit = 1'b0;
        viol   = 1'b0;
        unique case (ph)
            PH_LOW_OK: begin
                if (lat_rise) ph_n = PH_HIGH_WAIT;
            end
            PH_LOW_WAIT: begin
                if (lat_rise) begin
                    viol = 1'b1;
                    ph_n = PH_HIGH_WAIT;
                end else if (bclk_rise) begin
                    ph_n = PH_LOW_OK;
                end
            end
            PH_HIGH_WAIT: begin
                if (lat_fall) begin
                    viol = 1'b1;
                    ph_n = PH_LOW_WAIT;
                end else if (bclk_rise) begin
                    ph_n = PH_HIGH_OK;
                end
            end
            PH_HIGH_OK: begin
                if (lat_fall) begin
                    commit = 1'b1;
                    ph_n   = PH_LOW_WAIT;
                end
            end
            default: ph_n = PH_LOW_OK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ph <= PH_LOW_OK;
        else     ph <= ph_n;
    end

    assert_commit_viol_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(commit && viol));
endmodule

// File: rtl/serial_dac_rx.sv
module serial_dac_rx
    import dac_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bclk_i,
    input  logic              sdata_i,
    input  logic              lat_i,
    output logic [WORD_W-1:0] word_o,
    output logic [WORD_W-1:0] word_ob_o,
    output logic              upd_o,
    output logic              err_o
);
    pins_t raw, lvl, rise, fall;
    word_t sh, word_q;
    logic  commit, viol, upd_q, err_q;

    assign raw = '{lat: lat_i, sdata: sdata_i, bclk: bclk_i};

    dac_rx_sync #(.N(PINS_W), .STAGES(2)) u_sync (
        .clk (clk), .rst (rst), .din (raw),
        .lvl (lvl), .rise (rise), .fall (fall)
    );

    dac_rx_shift u_shift (
        .clk (clk), .rst (rst), .shift_en (rise.bclk),
        .din (lvl.sdata), .sh (sh)
    );

    dac_rx_guard u_guard (
        .clk (clk), .rst (rst), .bclk_rise (rise.bclk),
        .lat_rise (rise.lat), .lat_fall (fall.lat),
        .commit (commit), .viol (viol)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            upd_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            upd_q <= commit;
            if (commit) word_q <= sh;
            if (viol)   err_q  <= 1'b1;
        end
    end

    assign word_o    = word_q;
    assign word_ob_o = to_offset_bin(word_q);
    assign upd_o     = upd_q;
    assign err_o     = err_q;

    assert_strobe_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        upd_q |=> !upd_q);
    assert_word_moves_with_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        (word_q != $past(word_q)) |-> upd_q);
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);
    assert_viol_no_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        viol |=> !upd_q);
endmodule

// File: tb/tb_serial_dac_rx.sv
module tb_serial_dac_rx;
    logic clk = 0, rst = 1;
    logic bclk = 0, sdata = 0, lat = 0;
    logic [17:0] word, word_ob;
    logic upd, err;
    int total = 0, bad = 0, strobes = 0;
    bit done = 0;

    always #10 clk = ~clk;

    serial_dac_rx dut (
        .clk(clk), .rst(rst), .bclk_i(bclk), .sdata_i(sdata), .lat_i(lat),
        .word_o(word), .word_ob_o(word_ob), .upd_o(upd), .err_o(err)
    );

    always @(posedge clk) if (!rst && upd) strobes++;

    localparam int NV = 5;
    localparam logic [17:0] V_VAL [NV] = '{18'h1FFFF, 18'h20000, 18'h00000, 18'h3FFFF, 18'h15A5A};
    localparam int          V_PAD [NV] = '{0, 6, 2, 0, 4};
    localparam int          V_HI  [NV] = '{1, 3, 1, 18, 2};

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic waitc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_bclk();
        waitc(4); bclk = 1; waitc(4); bclk = 0;
    endtask

    // pad bits are ones so a wrong word length shows up
    task automatic send(logic [17:0] v, int pad, int hi, bit trail);
        int n;
        n = pad + 18;
        for (int i = 0; i < n; i++) begin
            sdata = (i < pad) ? 1'b1 : v[17 - (i - pad)];
            if (hi > 0 && i == n - hi) lat = 1;
            pulse_bclk();
        end
        if (hi == 0) begin lat = 1; waitc(4); end
        waitc(2);
        lat = 0;
        sdata = 0;
        if (trail) pulse_bclk();
        waitc(8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int s0;
        waitc(4); rst = 0; waitc(4);
        chk("R3 reset word", word, 18'h00000);
        chk("R4 reset ob", word_ob, 18'h20000);
        chk("R5 no strobe after reset", strobes, 0);
        chk("R8 reset err", err, 0);

        for (int k = 0; k < NV; k++) begin
            s0 = strobes;
            send(V_VAL[k], V_PAD[k], V_HI[k], 1'b1);
            chk("R1 R2 word", word, V_VAL[k]);
            chk("R4 offset bin", word_ob, {~V_VAL[k][17], V_VAL[k][16:0]});
            chk("R5 one strobe", strobes - s0, 1);
            chk("R7 no err on legal frame", err, 0);
        end

        // bit clocks alone must not move the word
        for (int i = 0; i < 20; i++) begin sdata = i[0]; pulse_bclk(); end
        waitc(8);
        chk("R3 clocks without latch", word, 18'h15A5A);

        // high-width violation
        s0 = strobes;
        send(18'h0AAAA, 0, 0, 1'b1);
        chk("R6 err set", err, 1);
        chk("R6 word held", word, 18'h15A5A);
        chk("R6 no strobe", strobes - s0, 0);

        // sticky
        s0 = strobes;
        send(18'h01234, 0, 1, 1'b1);
        chk("R8 err stays", err, 1);
        chk("R8 word still accepted", word, 18'h01234);

        rst = 1; waitc(3); rst = 0; waitc(4);
        chk("R8 reset clears err", err, 0);

        // low-width violation
        s0 = strobes;
        send(18'h12345, 3, 1, 1'b0);
        chk("R7 word latched", word, 18'h12345);
        chk("R7 no err yet", err, 0);
        lat = 1; waitc(6); lat = 0; waitc(8);
        chk("R7 err set", err, 1);
        chk("R7 word kept", word, 18'h12345);
        chk("R7 single strobe", strobes - s0, 1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule